// File: doc/BRIEF.md
# Shared Central Packet Buffer Manager

This block manages a storage pool that all ports of an eight-port switch share. The pool holds 128 chunks of 8 bytes each. An incoming packet of 1 to 255 bytes is written one byte per beat. The first beat also carries the packet length and the output port chosen by the sender. The manager takes chunks from a linked free list, fills them, and appends each finished chunk to the chain of the target output. Because routing is source-based, the manager never computes a destination. It uses the one supplied with the packet.

Each output raises a request when it can accept a byte. In every cycle at most one output is served. The grant goes to the output that was served least recently among those that request and have a complete chunk queued. After an output has read the last byte of a chunk, that chunk goes back to the free list in the following cycle. The write side can then reserve it again.

Top module: `cbm_central_buf`

## Requirements
- R1: After reset, a first beat of any length from 1 to 255 sees `wr_ready_o` high, and no output is granted even when all outputs request.
- R2: Each output delivers, on `rd_data_o`, the bytes of the packets addressed to it, in the order they were written.
- R3: On a first beat, `wr_ready_o` is high only when the number of unreserved free chunks is at least ceil(length/8). A length of 0 is never accepted. On every later beat of a packet, `wr_ready_o` is high.
- R4: The pool holds exactly 128 chunks. Once four 255-byte packets (32 chunks each) are stored and none has been read, even a 1-byte packet is refused.
- R5: `rd_eop_o` is high together with the grant that delivers the last byte of a packet, and low on all other grants.
- R6: `rd_gnt_o` is one-hot or zero. Among outputs that request and have data, the one served least recently wins. After reset, the priority order is port 0 first, then ascending.
- R7: A chunk becomes readable in the cycle after its eighth byte is written, or after the last byte of its packet if that comes earlier. Bytes of a partly filled chunk are never granted.
- R8: Let the last byte of a chunk be read at clock edge t. The chunk is back in the free pool at edge t+1, so a write that needs it can be accepted from the cycle after edge t+1, and not earlier.
- R9: An output that is not requesting, or whose queue is empty, is never granted, and its request does not change the grant given to other outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_valid_i | input | 1 | Write byte valid |
| wr_ready_o | output | 1 | Write byte accepted this cycle |
| wr_data_i | input | 8 | Write byte |
| wr_len_i | input | 8 | Packet length in bytes, sampled on the first beat |
| wr_port_i | input | 3 | Destination output, sampled on the first beat |
| rd_req_i | input | 8 | Per-output read request |
| rd_gnt_o | output | 8 | One-hot read grant |
| rd_data_o | output | 8 | Byte delivered to the granted output |
| rd_eop_o | output | 1 | Delivered byte ends its packet |

## Verification
The bench targets a pool that is exactly full. A design that counted chunks wrongly would accept a packet with too little space, or refuse one that fits. It also targets the return of a freed chunk. A design that freed the chunk one cycle early or late would move the edge at which `wr_ready_o` recovers. A request held on an output while its first chunk is still being filled checks that partial chunks stay hidden. Leaking them would show up as a grant with stale data. A random phase mixes concurrent writes and reads so that links and unlinks hit the same queue in one cycle, and so that free-list pushes and pops coincide, including with only one free chunk left. A design that mishandled this would lose or duplicate chunks and return corrupted bytes.

// File: rtl/cbm_pkg.sv
`timescale 1ns/1ps
package cbm_pkg;
  typedef enum logic {
    WR_IDLE,
    WR_BODY
  } wr_state_e;
endpackage

// File: rtl/cbm_lru_arb.sv
`timescale 1ns/1ps
module cbm_lru_arb #(
  parameter int unsigned N = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N-1:0]         req_i,
  output logic [N-1:0]         gnt_o,
  output logic [$clog2(N)-1:0] gnt_idx_o,
  output logic                 gnt_vld_o
);
  localparam int unsigned IDX_W = $clog2(N);

  // order_q[0] is the least recently served port
  logic [IDX_W-1:0] order_q [N];
  logic [IDX_W-1:0] sel_pos;
  logic             found;

  always_comb begin
    found   = 1'b0;
    sel_pos = '0;
    for (int i = 0; i < N; i++) begin
      if (!found && req_i[order_q[i]]) begin
        found   = 1'b1;
        sel_pos = IDX_W'(i);
      end
    end
    gnt_vld_o = found;
    gnt_idx_o = order_q[sel_pos];
    gnt_o     = found ? (N'(1) << gnt_idx_o) : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < N; i++) order_q[i] <= IDX_W'(i);
    end else if (found) begin
      for (int i = 0; i < N - 1; i++) begin
        if (IDX_W'(i) >= sel_pos) order_q[i] <= order_q[i+1];
      end
      order_q[N-1] <= gnt_idx_o;
    end
  end
endmodule

// File: rtl/cbm_chunk_store.sv
`timescale 1ns/1ps
module cbm_chunk_store #(
  parameter int unsigned NUM_CHUNKS  = 128,
  parameter int unsigned CHUNK_BYTES = 8,
  parameter int unsigned DATA_W      = 8
) (
  input  logic                           clk_i,
  input  logic                           wr_en_i,
  input  logic [$clog2(NUM_CHUNKS)-1:0]  wr_ptr_i,
  input  logic [$clog2(CHUNK_BYTES)-1:0] wr_off_i,
  input  logic [DATA_W-1:0]              wr_data_i,
  input  logic                           meta_en_i,
  input  logic [$clog2(CHUNK_BYTES)-1:0] meta_last_i,
  input  logic                           meta_eop_i,
  input  logic [$clog2(NUM_CHUNKS)-1:0]  rd_ptr_i,
  input  logic [$clog2(CHUNK_BYTES)-1:0] rd_off_i,
  output logic [DATA_W-1:0]              rd_data_o,
  output logic [$clog2(CHUNK_BYTES)-1:0] rd_last_o,
  output logic                           rd_eop_o
);
  localparam int unsigned PTR_W = $clog2(NUM_CHUNKS);
  localparam int unsigned OFF_W = $clog2(CHUNK_BYTES);
  localparam int unsigned DEPTH = NUM_CHUNKS * CHUNK_BYTES;

  logic [DATA_W-1:0] mem_q  [DEPTH];
  logic [OFF_W-1:0]  last_q [NUM_CHUNKS];
  logic              eop_q  [NUM_CHUNKS];

  always_ff @(posedge clk_i) begin
    if (wr_en_i) mem_q[{wr_ptr_i, wr_off_i}] <= wr_data_i;
    if (meta_en_i) begin
      last_q[wr_ptr_i] <= meta_last_i;
      eop_q[wr_ptr_i]  <= meta_eop_i;
    end
  end

  assign rd_data_o = mem_q[{rd_ptr_i, rd_off_i}];
  assign rd_last_o = last_q[rd_ptr_i];
  assign rd_eop_o  = eop_q[rd_ptr_i];
endmodule

// File: rtl/cbm_central_buf.sv
`timescale 1ns/1ps
module cbm_central_buf
  import cbm_pkg::*;
#(
  parameter int unsigned NUM_PORTS   = 8,
  parameter int unsigned NUM_CHUNKS  = 128,
  parameter int unsigned CHUNK_BYTES = 8,
  parameter int unsigned MAX_LEN     = 255,
  parameter int unsigned DATA_W      = 8
) (
  input  logic                               clk_i,
  input  logic                               rst_ni,
  input  logic                               wr_valid_i,
  output logic                               wr_ready_o,
  input  logic [DATA_W-1:0]                  wr_data_i,
  input  logic [$clog2(MAX_LEN+1)-1:0]       wr_len_i,
  input  logic [$clog2(NUM_PORTS)-1:0]       wr_port_i,
  input  logic [NUM_PORTS-1:0]               rd_req_i,
  output logic [NUM_PORTS-1:0]               rd_gnt_o,
  output logic [DATA_W-1:0]                  rd_data_o,
  output logic                               rd_eop_o
);
  localparam int unsigned PORT_W = $clog2(NUM_PORTS);
  localparam int unsigned PTR_W  = $clog2(NUM_CHUNKS);
  localparam int unsigned OFF_W  = $clog2(CHUNK_BYTES);
  localparam int unsigned LEN_W  = $clog2(MAX_LEN + 1);
  localparam int unsigned CNT_W  = $clog2(NUM_CHUNKS + 1);
  localparam logic [PTR_W:0] NIL = {1'b1, {PTR_W{1'b0}}};

  // chunk links, shared by the free list and every output chain
  logic [PTR_W-1:0] next_q [NUM_CHUNKS];

  // free list and reservation
  logic [PTR_W-1:0] fl_head_q, fl_tail_q;
  logic [CNT_W-1:0] fl_cnt_q, avail_q;
  logic             ret_vld_q;
  logic [PTR_W-1:0] ret_ptr_q;

  // output chains
  logic [PTR_W:0]   q_head_q [NUM_PORTS];
  logic [PTR_W-1:0] q_tail_q [NUM_PORTS];
  logic [OFF_W-1:0] rd_off_q [NUM_PORTS];

  // write packet state
  wr_state_e        wr_state_q;
  logic [LEN_W-1:0] wr_rem_q;
  logic [PORT_W-1:0] wr_dest_q;
  logic [PTR_W-1:0] wr_cur_q;
  logic [OFF_W-1:0] wr_off_q;

  logic             wr_busy, wr_fire, first_acc, fl_pop, chunk_done, pkt_last;
  logic [CNT_W:0]   need;
  logic [OFF_W-1:0] cur_off;
  logic [LEN_W-1:0] cur_rem;
  logic [PORT_W-1:0] cur_dest;
  logic [PTR_W-1:0] cur_chunk;

  logic [NUM_PORTS-1:0] q_nonempty, q_single, q_link, q_pop, arb_req;
  logic [PORT_W-1:0]    gnt_idx;
  logic                 gnt_vld, chunk_end;
  logic [PTR_W-1:0]     rd_ptr;
  logic [OFF_W-1:0]     rd_off, rd_last;
  logic [DATA_W-1:0]    st_data;
  logic                 st_eop;

  logic             fl_nx_we, q_nx_we;
  logic [PTR_W-1:0] q_nx_addr;

  // ---------------- write side ----------------
  always_comb begin
    wr_busy   = (wr_state_q == WR_BODY);
    need      = (CNT_W+1)'(({1'b0, wr_len_i} + (LEN_W+1)'(CHUNK_BYTES - 1)) >> OFF_W);
    wr_ready_o = wr_busy ? 1'b1
                         : ((wr_len_i != '0) && ({1'b0, avail_q} >= need));
    wr_fire   = wr_valid_i && wr_ready_o;
    first_acc = wr_fire && !wr_busy;
    cur_off   = wr_busy ? wr_off_q  : '0;
    cur_rem   = wr_busy ? wr_rem_q  : wr_len_i;
    cur_dest  = wr_busy ? wr_dest_q : wr_port_i;
    cur_chunk = (cur_off == '0) ? fl_head_q : wr_cur_q;
    pkt_last  = (cur_rem == LEN_W'(1));
    fl_pop    = wr_fire && (cur_off == '0);
    chunk_done = wr_fire && (pkt_last || (cur_off == OFF_W'(CHUNK_BYTES - 1)));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_state_q <= WR_IDLE;
      wr_rem_q   <= '0;
      wr_dest_q  <= '0;
      wr_cur_q   <= '0;
      wr_off_q   <= '0;
    end else if (wr_fire) begin
      wr_state_q <= pkt_last ? WR_IDLE : WR_BODY;
      wr_rem_q   <= cur_rem - LEN_W'(1);
      wr_dest_q  <= cur_dest;
      wr_cur_q   <= cur_chunk;
      wr_off_q   <= cur_off + OFF_W'(1);
    end
  end

  // ---------------- read side ----------------
  generate
    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      assign q_nonempty[p] = ~q_head_q[p][PTR_W];
      assign q_single[p]   = q_nonempty[p] && (q_head_q[p][PTR_W-1:0] == q_tail_q[p]);
      assign q_link[p]     = chunk_done && (cur_dest == PORT_W'(p));
      assign q_pop[p]      = chunk_end && rd_gnt_o[p];
    end
  endgenerate

  assign arb_req = rd_req_i & q_nonempty;

  cbm_lru_arb #(.N(NUM_PORTS)) u_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (arb_req),
    .gnt_o     (rd_gnt_o),
    .gnt_idx_o (gnt_idx),
    .gnt_vld_o (gnt_vld)
  );

  assign rd_ptr    = q_head_q[gnt_idx][PTR_W-1:0];
  assign rd_off    = rd_off_q[gnt_idx];
  assign chunk_end = gnt_vld && (rd_off == rd_last);
  assign rd_data_o = gnt_vld ? st_data : '0;
  assign rd_eop_o  = chunk_end && st_eop;

  cbm_chunk_store #(
    .NUM_CHUNKS  (NUM_CHUNKS),
    .CHUNK_BYTES (CHUNK_BYTES),
    .DATA_W      (DATA_W)
  ) u_store (
    .clk_i       (clk_i),
    .wr_en_i     (wr_fire),
    .wr_ptr_i    (cur_chunk),
    .wr_off_i    (cur_off),
    .wr_data_i   (wr_data_i),
    .meta_en_i   (chunk_done),
    .meta_last_i (cur_off),
    .meta_eop_i  (pkt_last),
    .rd_ptr_i    (rd_ptr),
    .rd_off_i    (rd_off),
    .rd_data_o   (st_data),
    .rd_last_o   (rd_last),
    .rd_eop_o    (st_eop)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        q_head_q[p] <= NIL;
        q_tail_q[p] <= '0;
        rd_off_q[p] <= '0;
      end
    end else begin
      for (int p = 0; p < NUM_PORTS; p++) begin
        if (q_pop[p]) begin
          if (q_single[p]) q_head_q[p] <= q_link[p] ? {1'b0, cur_chunk} : NIL;
          else             q_head_q[p] <= {1'b0, next_q[q_head_q[p][PTR_W-1:0]]};
        end else if (q_link[p] && !q_nonempty[p]) begin
          q_head_q[p] <= {1'b0, cur_chunk};
        end
        if (q_link[p]) q_tail_q[p] <= cur_chunk;
        if (rd_gnt_o[p]) rd_off_q[p] <= q_pop[p] ? '0 : rd_off_q[p] + OFF_W'(1);
      end
    end
  end

  // ---------------- free list ----------------
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fl_head_q <= '0;
      fl_tail_q <= PTR_W'(NUM_CHUNKS - 1);
      fl_cnt_q  <= CNT_W'(NUM_CHUNKS);
      avail_q   <= CNT_W'(NUM_CHUNKS);
      ret_vld_q <= 1'b0;
      ret_ptr_q <= '0;
    end else begin
      fl_cnt_q  <= fl_cnt_q + CNT_W'(ret_vld_q) - CNT_W'(fl_pop);
      avail_q   <= avail_q - (first_acc ? need[CNT_W-1:0] : '0) + CNT_W'(ret_vld_q);
      ret_vld_q <= chunk_end;
      ret_ptr_q <= rd_ptr;
      if (fl_pop && !(ret_vld_q && fl_cnt_q == CNT_W'(1))) fl_head_q <= next_q[fl_head_q];
      if (ret_vld_q) begin
        fl_tail_q <= ret_ptr_q;
        // list empties by this cycle's pop (or was empty): returned chunk is new head
        if (fl_cnt_q == CNT_W'(fl_pop)) fl_head_q <= ret_ptr_q;
      end
    end
  end

  // ---------------- link array ----------------
  always_comb begin
    fl_nx_we  = ret_vld_q && (fl_cnt_q != CNT_W'(fl_pop));
    q_nx_addr = q_tail_q[cur_dest];
    q_nx_we   = chunk_done && q_nonempty[cur_dest]
                && !(q_pop[cur_dest] && q_single[cur_dest]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NUM_CHUNKS; i++) next_q[i] <= PTR_W'(i + 1);
    end else begin
      for (int i = 0; i < NUM_CHUNKS; i++) begin
        if (fl_nx_we && fl_tail_q == PTR_W'(i)) next_q[i] <= ret_ptr_q;
        if (q_nx_we && q_nx_addr == PTR_W'(i))  next_q[i] <= cur_chunk;
      end
    end
  end
endmodule

// File: rtl/cbm_central_buf_chk.sv
`timescale 1ns/1ps
module cbm_central_buf_chk #(
  parameter int unsigned NUM_PORTS  = 8,
  parameter int unsigned NUM_CHUNKS = 128,
  parameter int unsigned MAX_LEN    = 255
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic                             wr_ready_o,
  input logic [$clog2(MAX_LEN+1)-1:0]     wr_len_i,
  input logic [NUM_PORTS-1:0]             rd_req_i,
  input logic [NUM_PORTS-1:0]             rd_gnt_o,
  input logic                             wr_busy,
  input logic                             first_acc,
  input logic                             fl_pop,
  input logic                             ret_vld_q,
  input logic [$clog2(NUM_CHUNKS+1)-1:0]  avail_q,
  input logic [$clog2(NUM_CHUNKS+1)-1:0]  fl_cnt_q,
  input logic [NUM_PORTS-1:0]             q_nonempty
);
  localparam int unsigned CNT_W = $clog2(NUM_CHUNKS + 1);

  assert_gnt_onehot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rd_gnt_o));

  assert_gnt_requested_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_gnt_o & ~rd_req_i) == '0);

  assert_gnt_has_chunk_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_gnt_o & ~q_nonempty) == '0);

  assert_body_ready_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_busy |-> wr_ready_o);

  assert_zero_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_busy && wr_len_i == '0) |-> !wr_ready_o);

  assert_no_overflow_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fl_cnt_q >= avail_q) && (fl_cnt_q <= CNT_W'(NUM_CHUNKS)));

  assert_pop_backed_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fl_pop |-> (fl_cnt_q != '0));

  assert_return_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ret_vld_q && !first_acc) |=> (avail_q == $past(avail_q) + CNT_W'(1)));
endmodule

bind cbm_central_buf cbm_central_buf_chk #(
  .NUM_PORTS  (NUM_PORTS),
  .NUM_CHUNKS (NUM_CHUNKS),
  .MAX_LEN    (MAX_LEN)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_ready_o (wr_ready_o),
  .wr_len_i   (wr_len_i),
  .rd_req_i   (rd_req_i),
  .rd_gnt_o   (rd_gnt_o),
  .wr_busy    (wr_busy),
  .first_acc  (first_acc),
  .fl_pop     (fl_pop),
  .ret_vld_q  (ret_vld_q),
  .avail_q    (avail_q),
  .fl_cnt_q   (fl_cnt_q),
  .q_nonempty (q_nonempty)
);

// File: tb/tb_cbm_central_buf.sv
`timescale 1ns/1ps
module tb_cbm_central_buf;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [7:0] wr_data = '0;
  logic [7:0] wr_len = '0;
  logic [2:0] wr_port = '0;
  logic [7:0] rd_req = '0;
  logic [7:0] rd_gnt;
  logic [7:0] rd_data;
  logic       rd_eop;

  always #10 clk = ~clk;

  cbm_central_buf dut (
    .clk_i      (clk),
    .rst_ni     (rst_n),
    .wr_valid_i (wr_valid),
    .wr_ready_o (wr_ready),
    .wr_data_i  (wr_data),
    .wr_len_i   (wr_len),
    .wr_port_i  (wr_port),
    .rd_req_i   (rd_req),
    .rd_gnt_o   (rd_gnt),
    .rd_data_o  (rd_data),
    .rd_eop_o   (rd_eop)
  );

  // reference model
  int qb[8][$];   // visible bytes per output: data | eop<<8
  int qc[8][$];   // visible chunk sizes per output
  int pend[$];
  int order[$];
  int m_avail;
  bit m_ret;
  bit m_busy;
  int m_rem, m_dest, m_off;

  int  errs = 0;
  int  checks = 0;
  bit  done = 1'b0;
  bit  rand_req = 1'b0;
  bit  obs_ready;
  bit [7:0] obs_gnt;

  task automatic chk(int act, int exp, string what);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  function automatic bit pending();
    for (int p = 0; p < 8; p++) if (qb[p].size() > 0) return 1'b1;
    return 1'b0;
  endfunction

  task automatic cyc(bit v, int d, int len, int port, bit [7:0] req_in, output bit acc);
    bit [7:0] req;
    bit [7:0] eg;
    bit       er;
    bit       old_ret;
    int       w;
    int       need;
    @(negedge clk);
    req = rand_req ? 8'($urandom) : req_in;
    wr_valid = v;
    wr_data  = 8'(d);
    wr_len   = 8'(len);
    wr_port  = 3'(port);
    rd_req   = req;
    #1;
    need = (len + 7) / 8;
    er = m_busy ? 1'b1 : (len != 0 && m_avail >= need);
    w = -1;
    foreach (order[i]) if (w < 0 && req[order[i]] && qb[order[i]].size() > 0) w = order[i];
    eg = (w >= 0) ? 8'(1 << w) : 8'h00;
    obs_ready = wr_ready;
    obs_gnt   = rd_gnt;
    chk(int'(wr_ready), int'(er), "R3 wr_ready");
    chk(int'(rd_gnt), int'(eg), "R6 rd_gnt");
    if (w >= 0) begin
      chk(int'(rd_data), qb[w][0] & 255, "R2 rd_data");
      chk(int'(rd_eop), qb[w][0] >> 8, "R5 rd_eop");
    end
    acc = v && er;
    @(posedge clk);
    old_ret = m_ret;
    m_ret = 1'b0;
    if (old_ret) m_avail++;
    if (acc) begin
      if (!m_busy) begin
        m_avail -= need;
        m_busy = 1'b1;
        m_rem  = len;
        m_dest = port;
        m_off  = 0;
      end
      pend.push_back((d & 255) | ((m_rem == 1) ? 256 : 0));
      m_rem--;
      m_off++;
      if (m_off == 8 || m_rem == 0) begin
        foreach (pend[i]) qb[m_dest].push_back(pend[i]);
        qc[m_dest].push_back(pend.size());
        pend.delete();
        m_off = 0;
      end
      if (m_rem == 0) m_busy = 1'b0;
    end
    if (w >= 0) begin
      void'(qb[w].pop_front());
      qc[w][0] = qc[w][0] - 1;
      if (qc[w][0] == 0) begin
        void'(qc[w].pop_front());
        m_ret = 1'b1;
      end
      for (int i = 0; i < order.size(); i++) begin
        if (order[i] == w) begin
          order.delete(i);
          break;
        end
      end
      order.push_back(w);
    end
  endtask

  task automatic send_pkt(int port, int len, int seed, bit [7:0] req);
    bit acc;
    for (int i = 0; i < len; i++) begin
      do cyc(1'b1, seed + i, len, port, req, acc); while (!acc);
    end
  endtask

  task automatic drain(bit [7:0] mask);
    bit acc;
    int k = 0;
    while (pending() && k < 6000) begin
      cyc(1'b0, 0, 0, 0, mask, acc);
      k++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  initial begin
    bit acc;
    m_avail = 128;
    m_ret = 1'b0;
    m_busy = 1'b0;
    for (int i = 0; i < 8; i++) order.push_back(i);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R1: reset state
    cyc(1'b0, 0, 255, 0, 8'hFF, acc);
    chk(int'(obs_ready), 1, "R1 ready after reset");
    chk(int'(obs_gnt), 0, "R1 no grant after reset");

    // R7: partial chunk stays hidden while output requests
    for (int i = 0; i < 20; i++) begin
      cyc(1'b1, 100 + i, 20, 3, 8'h08, acc);
      if (i == 7) chk(int'(obs_gnt), 0, "R7 partial chunk hidden");
      if (i == 8) chk(int'(obs_gnt), 8'h08, "R7 full chunk visible");
    end
    drain(8'h08);

    // R3 zero length refused; R9 empty output not granted
    for (int i = 0; i < 3; i++) begin
      cyc(1'b1, 0, 0, 2, 8'h04, acc);
      chk(int'(obs_ready), 0, "R3 zero length refused");
      chk(int'(obs_gnt), 0, "R9 empty output not granted");
    end

    // R6: least recently served order among several outputs
    send_pkt(5, 3, 10, 8'h00);
    send_pkt(6, 3, 20, 8'h00);
    send_pkt(7, 9, 30, 8'h00);
    send_pkt(0, 3, 40, 8'h00);
    repeat (4) cyc(1'b0, 0, 0, 0, 8'hE1, acc);
    repeat (4) cyc(1'b0, 0, 0, 0, 8'h61, acc);
    drain(8'hFF);

    // R4: fill all 128 chunks
    for (int p = 0; p < 4; p++) send_pkt(p, 255, p * 7, 8'h00);
    cyc(1'b1, 0, 1, 4, 8'h00, acc);
    chk(int'(obs_ready), 0, "R4 pool full refuses 1 byte");

    // R8: read one chunk of port 0, then watch the return timing
    for (int i = 0; i < 8; i++) cyc(1'b1, 0, 1, 4, 8'h01, acc);
    cyc(1'b1, 0, 1, 4, 8'h00, acc);
    chk(int'(obs_ready), 0, "R8 chunk not free one cycle after read");
    cyc(1'b1, 8'h5A, 1, 4, 8'h00, acc);
    chk(int'(obs_ready), 1, "R8 chunk free two cycles after read");
    drain(8'hFF);

    // mixed traffic with random requests
    rand_req = 1'b1;
    for (int n = 0; n < 250; n++) begin
      int len;
      len = ($urandom % 8 == 0) ? 1 + int'($urandom % 255) : 1 + int'($urandom % 24);
      send_pkt(int'($urandom % 8), len, int'($urandom % 256), 8'h00);
    end
    rand_req = 1'b0;
    drain(8'hFF);

    // R4: all chunks came back: 128 chunks fit again, then full
    for (int p = 4; p < 8; p++) send_pkt(p, 255, p * 3, 8'h00);
    cyc(1'b1, 0, 1, 0, 8'h00, acc);
    chk(int'(obs_ready), 0, "R4 pool full again after recycling");
    drain(8'hFF);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule